// File: doc/BRIEF.md
# Base and Bounds Address Relocation Unit

This block sits between a processor's data-address path and the memory system and gives the running program a private, relocatable window of memory. Every logical address is compared against a limit register; when it is below the limit, a base register is added to produce the physical address. An address at or above the limit is a protection fault. A sum that carries out of the address width is also a protection fault. A faulting request never reaches memory.

The base and limit are privileged state. Only a write issued in supervisor mode can change them. A write attempted in user mode is dropped and flagged. A supervisor request may also ask for an absolute access, which skips both the addition and the limit check so that system code can reach any physical location. Results come out of a single register stage with valid/ready flow control toward memory.

Top module: `reloc_unit`

## Requirements
- R1: After reset, base and limit are both 0, `mem_valid`, `fault` and `priv_viol` are low, and `req_ready` is high. Every relocated access faults until the registers are programmed.
- R2: An accepted relocated request with `req_addr` < limit and no carry produces `mem_valid`=1 and `mem_addr` = base + `req_addr` in the cycle after acceptance.
- R3: An accepted relocated request with `req_addr` >= limit raises `fault` in the cycle after acceptance and leaves `mem_valid` low.
- R4: An accepted relocated request whose sum base + `req_addr` carries out of `ADDR_W` bits raises `fault` and leaves `mem_valid` low.
- R5: A write with `cfg_we`=1 and `cfg_priv`=1 loads `cfg_data` into the base when `cfg_sel`=0 or into the limit when `cfg_sel`=1. The new value applies to requests accepted after that clock edge.
- R6: A write with `cfg_we`=1 and `cfg_priv`=0 changes neither register and pulses `priv_viol` high for the following cycle.
- R7: A request with `req_priv`=1 and `req_abs`=1 yields `mem_addr` = `req_addr` with no limit check and no fault.
- R8: `req_abs` has no effect when `req_priv`=0. The request is relocated and checked as usual.
- R9: While `mem_valid`=1 and `mem_ready`=0, `req_ready` is low and `mem_valid` and `mem_addr` hold their values.
- R10: `fault` is high for exactly one cycle per faulting request and is low in a cycle that follows no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Logical-address request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Logical address |
| req_priv | input | 1 | Request issued in supervisor mode |
| req_abs | input | 1 | Absolute (unrelocated) access, honoured only in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_data | input | ADDR_W | Register write data |
| cfg_priv | input | 1 | Write issued in supervisor mode |
| mem_valid | output | 1 | Physical request valid |
| mem_ready | input | 1 | Memory accepts the physical request |
| mem_addr | output | ADDR_W | Physical address |
| fault | output | 1 | One-cycle protection-fault pulse |
| priv_viol | output | 1 | One-cycle pulse on a user-mode register write |

## Verification
Carry-out faults are the hardest case to reach, because they need an address that passes the limit check while the base sits near the top of the address space. The bench builds with an 8-bit address and programs base/limit pairs where the limit exceeds 256 minus the base. It then sweeps every logical address, so that legal, over-limit and wrapping addresses all occur in the same pass. User-mode write attempts are checked through later accesses, which show that the relocation did not change.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        XK_MAPPED     = 2'd0,
        XK_ABSOLUTE   = 2'd1,
        XK_OVER_LIMIT = 2'd2,
        XK_CARRY      = 2'd3
    } xlate_kind_e;

    function automatic logic kind_faults(xlate_kind_e k);
        return (k == XK_OVER_LIMIT) || (k == XK_CARRY);
    endfunction

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              wr_priv,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic              viol_o
);
    logic wr_ok;
    logic wr_bad;

    assign wr_ok  = wr_en && wr_priv;
    assign wr_bad = wr_en && !wr_priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_o  <= '0;
            limit_o <= '0;
            viol_o  <= 1'b0;
        end else begin
            viol_o <= wr_bad;
            if (wr_ok) begin
                if (wr_sel == SEL_BASE) base_o  <= wr_data;
                else                    limit_o <= wr_data;
            end
        end
    end

    // R6: a user-mode write leaves both registers untouched
    p_user_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> ($stable(base_o) && $stable(limit_o)));

    // R6: a violation flag is always caused by a user write one cycle earlier
    p_viol_src_r6: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> $past(wr_en && !wr_priv));

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              [ADDR_W-1:0] logical,
    input  logic              [ADDR_W-1:0] base,
    input  logic              [ADDR_W-1:0] limit,
    input  logic                           priv,
    input  logic                           abs_req,
    output logic              [ADDR_W-1:0] phys,
    output xlate_kind_e                    kind
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;
    logic             bypass;

    // one adder, shared by every relocated access
    assign sum    = {1'b0, base} + {1'b0, logical};
    assign bypass = priv && abs_req;

    always_comb begin
        phys = sum[ADDR_W-1:0];
        kind = XK_MAPPED;
        if (bypass) begin
            phys = logical;
            kind = XK_ABSOLUTE;
        end else if (logical >= limit) begin
            kind = XK_OVER_LIMIT;
        end else if (sum[ADDR_W]) begin
            kind = XK_CARRY;
        end
    end

endmodule

// File: rtl/reloc_stage.sv
module reloc_stage
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_phys,
    input  xlate_kind_e       in_kind,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              fault_o
);
    logic take;
    logic bad;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;
    assign bad      = kind_faults(in_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            fault_o   <= 1'b0;
        end else begin
            fault_o <= take && bad;
            if (take) begin
                out_valid <= !bad;
                if (!bad) out_addr <= in_phys;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R9: a stalled physical request holds still
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    // R3: a fault never comes with a memory request
    p_fault_novalid_r3: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !out_valid);

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
    import reloc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_priv,
    input  logic              req_abs,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              cfg_priv,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fault,
    output logic              priv_viol
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W-1:0] phys;
    xlate_kind_e       kind;

    reloc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_sel  (reg_sel_e'(cfg_sel)),
        .wr_data (cfg_data),
        .wr_priv (cfg_priv),
        .base_o  (base_q),
        .limit_o (limit_q),
        .viol_o  (priv_viol)
    );

    reloc_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .logical (req_addr),
        .base    (base_q),
        .limit   (limit_q),
        .priv    (req_priv),
        .abs_req (req_abs),
        .phys    (phys),
        .kind    (kind)
    );

    reloc_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_phys   (phys),
        .in_kind   (kind),
        .out_valid (mem_valid),
        .out_ready (mem_ready),
        .out_addr  (mem_addr),
        .fault_o   (fault)
    );

    // R3: an access classified as mapped lies below the limit
    p_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && kind == XK_MAPPED) |-> (req_addr < limit_q));

    // R7: supervisor absolute access passes the logical address straight through
    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_priv && req_abs)
        |=> (mem_valid && !fault && mem_addr == $past(req_addr)));

endmodule

// File: tb/reloc_unit_test.sv
module reloc_unit_test;
    localparam int AW = 8;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_priv, req_abs;
    logic [AW-1:0] req_addr;
    logic          cfg_we, cfg_sel, cfg_priv;
    logic [AW-1:0] cfg_data;
    logic          mem_valid, mem_ready, fault, priv_viol;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;

    int cur_base = 0;
    int cur_lim  = 0;

    always #4 clk = ~clk;

    reloc_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_priv(req_priv), .req_abs(req_abs),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_priv(cfg_priv),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .fault(fault), .priv_viol(priv_viol)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input bit sel, input int data, input bit priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = AW'(data); cfg_priv = priv;
        @(negedge clk);
        cfg_we = 1'b0;
        if (priv) begin
            if (sel) cur_lim = data; else cur_base = data;
            check(priv_viol == 1'b0, "R5 no viol on supervisor write", priv_viol, 0);
        end else begin
            check(priv_viol == 1'b1, "R6 viol pulse", priv_viol, 1);
            @(negedge clk);
            check(priv_viol == 1'b0, "R6 viol one cycle", priv_viol, 0);
        end
    endtask

    // one access; expected result computed arithmetically
    task automatic access(input int a, input bit priv, input bit absr, input string tag);
        bit exp_fault;
        int exp_pa;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(a); req_priv = priv; req_abs = absr;
        if (priv && absr) begin
            exp_fault = 1'b0; exp_pa = a;
        end else if (a >= cur_lim) begin
            exp_fault = 1'b1; exp_pa = 0;
        end else if (cur_base + a >= SPAN) begin
            exp_fault = 1'b1; exp_pa = 0;
        end else begin
            exp_fault = 1'b0; exp_pa = cur_base + a;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(fault == exp_fault, tag, fault, exp_fault);
        check(mem_valid == !exp_fault, tag, mem_valid, !exp_fault);
        if (!exp_fault) check(mem_addr == AW'(exp_pa), tag, mem_addr, exp_pa);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_addr = 0; req_priv = 0; req_abs = 0;
        cfg_we = 0; cfg_sel = 0; cfg_data = 0; cfg_priv = 0;
        mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mem_valid == 0, "R1 mem_valid after reset", mem_valid, 0);
        check(fault == 0, "R1 fault after reset", fault, 0);
        check(priv_viol == 0, "R1 priv_viol after reset", priv_viol, 0);
        check(req_ready == 1, "R1 req_ready after reset", req_ready, 1);
        access(0, 1'b0, 1'b0, "R1 access faults with zero limit");
        access(5, 1'b1, 1'b0, "R1 supervisor relocated access faults");

        // R10 fault pulse ends when no request follows
        @(negedge clk);
        check(fault == 0, "R10 fault returns low", fault, 0);

        // sweeps over base/limit pairs: R2, R3, R4, R8
        for (int c = 0; c < 4; c++) begin
            int b, l;
            case (c)
                0: begin b = 8'h10; l = 8'h40; end
                1: begin b = 8'hC0; l = 8'h80; end
                2: begin b = 8'h00; l = 8'hFF; end
                default: begin b = 8'hF0; l = 8'h30; end
            endcase
            write_reg(1'b0, b, 1'b1);
            write_reg(1'b1, l, 1'b1);
            for (int a = 0; a < SPAN; a++)
                access(a, 1'b0, (a % 3) == 0, "R2/R3/R4/R8 user sweep");
        end

        // R4 explicit carry case: base C0, limit 80, address 50 wraps
        write_reg(1'b0, 8'hC0, 1'b1);
        write_reg(1'b1, 8'h80, 1'b1);
        access(8'h50, 1'b0, 1'b0, "R4 carry fault");
        access(8'h3F, 1'b0, 1'b0, "R2 last address before carry");

        // R7 supervisor absolute sweep ignores limit and base
        for (int a = 0; a < SPAN; a++)
            access(a, 1'b1, 1'b1, "R7 absolute sweep");

        // R6 user writes ignored; observed through later accesses
        write_reg(1'b0, 8'h01, 1'b0);
        write_reg(1'b1, 8'hFF, 1'b0);
        access(8'h10, 1'b0, 1'b0, "R6 base unchanged");
        access(8'h90, 1'b0, 1'b0, "R6 limit unchanged");

        // R5 new value applies to the very next request
        write_reg(1'b0, 8'h05, 1'b1);
        access(8'h10, 1'b0, 1'b0, "R5 new base applied");

        // R10 back-to-back faults then idle
        access(8'hA0, 1'b0, 1'b0, "R10 first fault");
        access(8'hA1, 1'b0, 1'b0, "R10 second fault");
        @(negedge clk);
        check(fault == 0, "R10 pulse ends", fault, 0);

        // R9 backpressure
        mem_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h20; req_priv = 0; req_abs = 0;
        @(negedge clk);
        check(mem_valid == 1, "R9 stalled valid", mem_valid, 1);
        check(req_ready == 0, "R9 req_ready low", req_ready, 0);
        req_addr = 8'h30;
        repeat (3) begin
            @(negedge clk);
            check(mem_valid == 1 && mem_addr == 8'h25, "R9 held", mem_addr, 8'h25);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_valid == 1 && mem_addr == 8'h35, "R9 next after release", mem_addr, 8'h35);
        @(negedge clk);
        check(mem_valid == 0, "R9 drained", mem_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule